// File: doc/BRIEF.md
# Three-Wire Latched Serial Register Receiver

This block receives a serial word from a host over three logic lines: a serial clock, a data line and a latch strobe. Each rising edge of the serial clock pushes the data bit into a shift register. A rising edge on the latch strobe copies the gathered word into a parallel output register, and a one-cycle valid pulse goes with the copy. The serial lines arrive without any timing relation to the fast system clock. The block therefore passes them through a multi-stage synchronizer and finds their edges in the system-clock domain.

When the host is wired with data and strobe sharing one line and separated by voltage level, that level decoding happens outside this block. Here the two arrive as separate logic signals. A strobe edge that comes while the serial clock is high is discarded, and the output register stays unchanged. The output changes only on an accepted strobe, never because some number of bits has arrived.

Top module: `serial_latch_rx`

## Requirements
- R1: The data line value is shifted in once for each rising edge of the serial clock. A falling edge shifts nothing, and data that changes while the serial clock is high has no effect.
- R2: An accepted rising edge of the latch strobe loads the shift register contents into `word_o`.
- R3: A rising edge of the latch strobe that occurs while the synchronized serial clock is high is ignored. `word_o` keeps its value and no valid pulse is produced.
- R4: New bits enter at bit 0, so the first bit of a WIDTH-bit transfer ends up in bit WIDTH-1 of `word_o`.
- R5: If more than WIDTH bits arrive before a latch, only the last WIDTH bits are kept.
- R6: Each load of `word_o` is marked by `valid_o` being high for exactly one system-clock cycle.
- R7: While `rst_ni` is low, the shift register, `word_o` and `valid_o` are cleared to zero.
- R8: `word_o` does not change when bits arrive without a latch, however many bits arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| lat_i | input | 1 | Latch strobe from the host |
| word_o | output | WIDTH | Parallel output register |
| valid_o | output | 1 | One-cycle pulse on each output load |

## Verification
The bench builds the block with its default values: WIDTH of 16 and a two-stage synchronizer. With these values, a 20-bit burst is enough to show that older bits are dropped, and a 16-bit word shows that the first bit lands in the MSB. Each serial phase lasts six system clocks. That is longer than the synchronizer plus edge-detect latency, so the bench can raise the strobe while the synchronized serial clock is still high and show that the strobe is rejected. The bench also counts the valid pulses to confirm that each pulse is a single cycle wide.

// File: rtl/serial_latch_pkg.sv
package serial_latch_pkg;
  typedef struct packed {
    logic sck;
    logic sdi;
    logic lat;
  } line_t;

  localparam int unsigned LINE_W = $bits(line_t);
endpackage

// File: rtl/serial_latch_sync.sv
module serial_latch_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serial_latch_edge.sv
module serial_latch_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/serial_latch_core.sv
module serial_latch_core #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_rise_i,
  input  logic             sck_lvl_i,
  input  logic             sdi_lvl_i,
  input  logic             lat_rise_i,
  output logic [WIDTH-1:0] shift_o,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  logic [WIDTH-1:0] shift_q, word_q;
  logic             valid_q;
  logic             accept;

  // strobe qualified by serial clock low
  assign accept = lat_rise_i & ~sck_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
    end else if (sck_rise_i) begin
      shift_q <= {shift_q[WIDTH-2:0], sdi_lvl_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= accept;
      if (accept) word_q <= shift_q;
    end
  end

  assign shift_o = shift_q;
  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/serial_latch_rx.sv
module serial_latch_rx #(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             lat_i,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  import serial_latch_pkg::*;

  line_t            raw, lvl, rise;
  logic [WIDTH-1:0] shift_q;
  logic             sck_rise, sck_lvl, lat_rise;

  assign raw.sck = sck_i;
  assign raw.sdi = sdi_i;
  assign raw.lat = lat_i;

  serial_latch_sync #(.N(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (lvl)
  );

  serial_latch_edge #(.N(LINE_W)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .rise_o(rise)
  );

  assign sck_rise = rise.sck;
  assign sck_lvl  = lvl.sck;
  assign lat_rise = rise.lat;

  serial_latch_core #(.WIDTH(WIDTH)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_rise_i(sck_rise),
    .sck_lvl_i (sck_lvl),
    .sdi_lvl_i (lvl.sdi),
    .lat_rise_i(lat_rise),
    .shift_o   (shift_q),
    .word_o    (word_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/serial_latch_rx_chk.sv
module serial_latch_rx_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sck_rise,
  input logic             sck_lvl,
  input logic             lat_rise,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] word_o,
  input logic             valid_o
);
  AST_SHIFT_ONLY_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_rise |=> $stable(shift_q)); // R1

  AST_WORD_ONLY_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> valid_o); // R8

  AST_VALID_LOADS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (word_o == $past(shift_q))); // R2

  AST_NO_LATCH_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_rise && sck_lvl) |=> !valid_o); // R3

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
endmodule

bind serial_latch_rx serial_latch_rx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sck_rise(sck_rise),
  .sck_lvl (sck_lvl),
  .lat_rise(lat_rise),
  .shift_q (shift_q),
  .word_o  (word_o),
  .valid_o (valid_o)
);

// File: tb/serial_latch_rx_tb_top.sv
`timescale 1ns/1ps
module serial_latch_rx_tb_top;
  localparam int unsigned WIDTH = 16;
  localparam int unsigned PH    = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sck = 1'b0, sdi = 1'b0, lat = 1'b0;
  logic [WIDTH-1:0] word;
  logic             valid;

  int unsigned n_chk = 0, n_fail = 0, n_valid = 0;
  logic [WIDTH-1:0] exp_shift = '0, exp_word = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_latch_rx #(.WIDTH(WIDTH), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .sdi_i(sdi), .lat_i(lat),
    .word_o(word), .valid_o(valid)
  );

  always @(posedge clk) if (valid) n_valid++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ph();
    repeat (PH) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; wait_ph();
    sck = 1'b1; exp_shift = {exp_shift[WIDTH-2:0], b}; wait_ph();
    sdi = ~b; wait_ph();   // change while high: must not matter
    sck = 1'b0; wait_ph();
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    sdi = 1'b0;
  endtask

  task automatic do_latch();
    lat = 1'b1; wait_ph();
    lat = 1'b0; wait_ph();
    exp_word = exp_shift;
  endtask

  task automatic t_reset();
    check("R7 word after reset", word, 0);
    check("R7 valid after reset", valid, 0);
  endtask

  task automatic t_basic();
    int v0;
    send_bits(32'hA5C3, 16);
    check("R8 word held without latch", word, 0);
    v0 = n_valid;
    do_latch();
    check("R2 word after latch", word, exp_word);
    check("R4 first bit in MSB", word[WIDTH-1], 1'b1);
    check("R1 data at rising edge", word, 32'hA5C3);
    check("R6 single valid cycle", n_valid - v0, 1);
  endtask

  task automatic t_overflow();
    int v0;
    send_bits(32'hF1234, 20);
    check("R8 no update after bit count", word, 32'hA5C3);
    v0 = n_valid;
    do_latch();
    check("R5 last bits kept", word, 32'h1234);
    check("R6 single valid cycle", n_valid - v0, 1);
  endtask

  task automatic t_reject();
    int v0;
    send_bits(32'h0F0F, 15);
    v0 = n_valid;
    sdi = 1'b1; wait_ph();
    sck = 1'b1; exp_shift = {exp_shift[WIDTH-2:0], 1'b1}; wait_ph();
    lat = 1'b1; wait_ph();
    lat = 1'b0; wait_ph();
    sck = 1'b0; sdi = 1'b0; wait_ph();
    check("R3 word unchanged", word, 32'h1234);
    check("R3 no valid", n_valid - v0, 0);
    do_latch();
    check("R2 later latch accepted", word, 32'h1E1F);
    check("R6 single valid cycle", n_valid - v0, 1);
  endtask

  task automatic t_relatch();
    int v0;
    v0 = n_valid;
    do_latch();
    check("R2 relatch same shift", word, 32'h1E1F);
    check("R6 valid per latch", n_valid - v0, 1);
  endtask

  task automatic t_mid_reset();
    send_bits(32'h3, 2);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R7 async clear word", word, 0);
    rst_ni = 1'b1; exp_shift = '0;
    wait_ph();
    do_latch();
    check("R7 shift cleared", word, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    wait_ph();
    t_reset();
    t_basic();
    t_overflow();
    t_reject();
    t_relatch();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule